// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit fixed-width instruction stream continues after the current instruction. Each cycle it takes the address of the current instruction, its 32-bit encoding and the two source register values that have already been read. From these it produces the address to fetch next, a flag that says whether control was redirected, and a request to write a return address into the register file.

It covers compare-and-branch, sign-test branches, the sign-test group whose variant is picked by the rt field, region-relative direct jumps, and jumps through a register. The link forms are included. All results are registered, so they show the inputs that were present at the previous rising clock edge. Fetch, register file access, delay slots and exceptions are handled outside this block.

Field positions used throughout:

| Field | Bits |
|---|---|
| opcode | [31:26] |
| rs | [25:21] |
| rt | [20:16] |
| rd | [15:11] |
| offset | [15:0] |
| funct | [5:0] |
| target index | [25:0] |

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `next_pc` equals the parameter `RESET_PC` (default 0), and `taken` and `link_we` are 0.
- R2: All outputs are registered. One rising edge after an instruction is presented, an instruction that is not a branch or jump gives `next_pc` = PC+4 with `taken` = 0 and `link_we` = 0. This includes opcode 000000 with a funct other than 001000 or 001001, and opcode 000001 with an rt code outside {00000, 00001, 10000, 10001}.
- R3: Opcode 000100 is taken when the rs value equals the rt value. Opcode 000101 is taken when they differ. A taken branch goes to PC+4 plus the sign-extended 16-bit offset times 4; otherwise the result is PC+4.
- R4: Opcode 000110 is taken when the rs value, read as signed, is zero or negative. Opcode 000111 is taken when it is strictly positive. The rt value has no effect on either.
- R5: Under opcode 000001, rt bit 0 picks the test: 0 means rs < 0 and 1 means rs >= 0, both signed. rt bit 4 picks the link form. The target is the same as in R3.
- R6: A link-form branch sets `link_we` = 1, `link_dst` = 31 and `link_val` = PC+4 only when it is taken. When it is not taken, `link_we` stays 0.
- R7: Opcode 000010 (plain) and opcode 000011 (link) always redirect. The target is the top 4 bits of PC+4, then the 26-bit target index, then two zero bits. The link form writes PC+4 into register 31.
- R8: Opcode 000000 with funct 001000 redirects to the rs value without a link. With funct 001001 it redirects to the rs value, sets `link_we` = 1, and writes PC+4 into the register named by the rd field.
- R9: Address arithmetic wraps modulo 2^32. Negative offsets branch backwards.
- R10: The region bits of a direct jump come from PC+4, not from PC. This matters when the current instruction is the last word of a 256 MB region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | Value of the register named by rs |
| rt_val | input | 32 | Value of the register named by rt |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | Control was redirected |
| link_we | output | 1 | Write the return address |
| link_dst | output | 5 | Register index for the return address |
| link_val | output | 32 | Return address (PC+4) |

## Verification
The assertions assume that the inputs hold steady across each rising edge. They also assume that every edge after reset carries a meaningful instruction, since each result is checked against the previous cycle's `cur_pc` and `instr`. The directed stimulus changes inputs only on falling edges and keeps presenting an instruction on every cycle once reset is released, so every registered result has a well-defined previous input. Word-aligned PCs are used throughout, which is what the zero low bits of direct targets rely on.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned OP_W  = 6;
  localparam int unsigned REG_W = 5;
  localparam int unsigned OFF_W = 16;
  localparam int unsigned IDX_W = 26;
  localparam int unsigned STEP  = 4;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
  localparam logic [OP_W-1:0] OP_SIGNGRP = 6'b000001;
  localparam logic [OP_W-1:0] OP_JDIR    = 6'b000010;
  localparam logic [OP_W-1:0] OP_JDIRL   = 6'b000011;
  localparam logic [OP_W-1:0] OP_BEQ     = 6'b000100;
  localparam logic [OP_W-1:0] OP_BNE     = 6'b000101;
  localparam logic [OP_W-1:0] OP_BLEZ    = 6'b000110;
  localparam logic [OP_W-1:0] OP_BGTZ    = 6'b000111;
  localparam logic [5:0]      FN_JREG    = 6'b001000;
  localparam logic [5:0]      FN_JREGL   = 6'b001001;

  typedef enum logic [1:0] {CT_NONE, CT_BRANCH, CT_DIRECT, CT_REG} ctl_e;
  typedef enum logic [2:0] {C_EQ, C_NE, C_LEZ, C_GTZ, C_LTZ, C_GEZ, C_ALWAYS} cond_e;

  typedef struct packed {
    ctl_e  ctl;
    cond_e cond;
    logic  link;
    logic  link_rd;
  } dec_t;

  function automatic logic [XLEN-1:0] f_seq(input logic [XLEN-1:0] pc);
    return pc + XLEN'(STEP);
  endfunction

  function automatic logic [XLEN-1:0] f_branch(input logic [XLEN-1:0] pc,
                                               input logic [OFF_W-1:0] off);
    logic [XLEN-1:0] disp;
    disp = {{(XLEN-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    return f_seq(pc) + disp;
  endfunction

  function automatic logic [XLEN-1:0] f_region(input logic [XLEN-1:0] pc,
                                               input logic [IDX_W-1:0] idx);
    logic [XLEN-1:0] s;
    s = f_seq(pc);
    return {s[XLEN-1:IDX_W+2], idx, 2'b00};
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic [REG_W-1:0] rt_f,
  input  logic [5:0]       fn,
  output dec_t             dec
);
  always_comb begin
    dec = '{ctl: CT_NONE, cond: C_ALWAYS, link: 1'b0, link_rd: 1'b0};
    case (op)
      OP_BEQ:  begin dec.ctl = CT_BRANCH; dec.cond = C_EQ;  end
      OP_BNE:  begin dec.ctl = CT_BRANCH; dec.cond = C_NE;  end
      OP_BLEZ: begin dec.ctl = CT_BRANCH; dec.cond = C_LEZ; end
      OP_BGTZ: begin dec.ctl = CT_BRANCH; dec.cond = C_GTZ; end
      OP_SIGNGRP: begin
        if (rt_f[3:1] == 3'b000) begin
          dec.ctl  = CT_BRANCH;
          dec.cond = rt_f[0] ? C_GEZ : C_LTZ;
          dec.link = rt_f[4];
        end
      end
      OP_JDIR:  dec.ctl = CT_DIRECT;
      OP_JDIRL: begin dec.ctl = CT_DIRECT; dec.link = 1'b1; end
      OP_SPECIAL: begin
        if (fn == FN_JREG) begin
          dec.ctl = CT_REG;
        end else if (fn == FN_JREGL) begin
          dec.ctl     = CT_REG;
          dec.link    = 1'b1;
          dec.link_rd = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  cond_e           cond,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            hit
);
  logic neg, zero;
  assign neg  = a[XLEN-1];
  assign zero = (a == '0);

  always_comb begin
    case (cond)
      C_EQ:     hit = (a == b);
      C_NE:     hit = (a != b);
      C_LEZ:    hit = neg | zero;
      C_GTZ:    hit = ~neg & ~zero;
      C_LTZ:    hit = neg;
      C_GEZ:    hit = ~neg;
      C_ALWAYS: hit = 1'b1;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  ctl_e             ctl,
  input  logic [XLEN-1:0]  pc,
  input  logic [IDX_W-1:0] low,
  input  logic [XLEN-1:0]  a,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  br_pc,
  output logic [XLEN-1:0]  dir_pc,
  output logic [XLEN-1:0]  tgt
);
  assign seq_pc = f_seq(pc);
  assign br_pc  = f_branch(pc, low[OFF_W-1:0]);
  assign dir_pc = f_region(pc, low);

  always_comb begin
    case (ctl)
      CT_BRANCH: tgt = br_pc;
      CT_DIRECT: tgt = dir_pc;
      CT_REG:    tgt = a;
      default:   tgt = seq_pc;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter logic [4:0]  LINK_REG = 5'd31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cur_pc,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] next_pc,
  output logic        taken,
  output logic        link_we,
  output logic [4:0]  link_dst,
  output logic [31:0] link_val
);
  dec_t             w_dec;
  logic             w_cond_true;
  logic             w_redirect;
  logic             w_link_req;
  logic [XLEN-1:0]  w_seq_pc, w_br_pc, w_dir_pc, w_tgt, w_next;
  logic [REG_W-1:0] w_dst;

  npc_decode u_dec (
    .op   (instr[31:26]),
    .rt_f (instr[20:16]),
    .fn   (instr[5:0]),
    .dec  (w_dec)
  );

  npc_cond u_cond (
    .cond (w_dec.cond),
    .a    (rs_val),
    .b    (rt_val),
    .hit  (w_cond_true)
  );

  npc_target u_tgt (
    .ctl    (w_dec.ctl),
    .pc     (cur_pc),
    .low    (instr[IDX_W-1:0]),
    .a      (rs_val),
    .seq_pc (w_seq_pc),
    .br_pc  (w_br_pc),
    .dir_pc (w_dir_pc),
    .tgt    (w_tgt)
  );

  assign w_redirect = (w_dec.ctl != CT_NONE) && w_cond_true;
  assign w_link_req = w_redirect && w_dec.link;
  assign w_next     = w_redirect ? w_tgt : w_seq_pc;
  assign w_dst      = w_dec.link_rd ? instr[15:11] : LINK_REG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc  <= RESET_PC;
      taken    <= 1'b0;
      link_we  <= 1'b0;
      link_dst <= LINK_REG;
      link_val <= '0;
    end else begin
      next_pc  <= w_next;
      taken    <= w_redirect;
      link_we  <= w_link_req;
      link_dst <= w_dst;
      link_val <= w_seq_pc;
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter logic [4:0] LINK_REG = 5'd31
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cur_pc,
  input logic [31:0] instr,
  input logic [31:0] next_pc,
  input logic        taken,
  input logic        link_we,
  input logic [4:0]  link_dst,
  input logic [31:0] link_val
);
  logic        primed;
  logic [31:0] seq_now;
  assign seq_now = cur_pc + 32'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  a_r6_link_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> taken);

  a_r2_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !taken |-> next_pc == $past(seq_now));

  a_r6_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    primed && link_we |-> link_val == $past(seq_now));

  a_r10_region_bits: assert property (@(posedge clk) disable iff (!rst_n)
    primed && taken && $past(instr[31:27]) == 5'b00001
      |-> next_pc[31:28] == $past(seq_now[31:28]) && next_pc[1:0] == 2'b00);

  a_r8_rd_only_regjump: assert property (@(posedge clk) disable iff (!rst_n)
    primed && link_we && link_dst != LINK_REG |-> $past(instr[31:26]) == 6'b000000);
endmodule

bind npc_unit npc_unit_chk #(.LINK_REG(LINK_REG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cur_pc   (cur_pc),
  .instr    (instr),
  .next_pc  (next_pc),
  .taken    (taken),
  .link_we  (link_we),
  .link_dst (link_dst),
  .link_val (link_val)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0, instr = '0, rs_val = '0, rt_val = '0;
  logic [31:0] next_pc, link_val;
  logic        taken, link_we;
  logic [4:0]  link_dst;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  npc_unit u0 (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .next_pc(next_pc), .taken(taken),
    .link_we(link_we), .link_dst(link_dst), .link_val(link_val)
  );

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction
  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rd,
                                        input logic [5:0] fn);
    return {6'b000000, rs, 5'd0, rd, 5'd0, fn};
  endfunction

  task automatic drive(input logic [31:0] pc, ins, a, b);
    @(negedge clk);
    cur_pc = pc; instr = ins; rs_val = a; rt_val = b;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic [31:0] npc, input logic tk,
                            input logic lwe, input logic [4:0] ldst, input logic [31:0] lval);
    n_chk++;
    if (next_pc !== npc || taken !== tk || link_we !== lwe ||
        (lwe && (link_dst !== ldst || link_val !== lval))) begin
      n_bad++;
      $display("FAIL %s: got npc=%h tk=%b lwe=%b dst=%0d lval=%h, want npc=%h tk=%b lwe=%b dst=%0d lval=%h",
               req, next_pc, taken, link_we, link_dst, link_val, npc, tk, lwe, ldst, lval);
    end
  endtask

  task automatic t_reset;
    #1;
    expect_out("R1", 32'h0, 1'b0, 1'b0, 5'd0, 32'h0);
  endtask

  task automatic t_plain;
    drive(32'h0000_0400, 32'h0064_1020, 32'h5, 32'h5);
    expect_out("R2 alu op", 32'h0000_0404, 0, 0, 0, 0);
    drive(32'h0000_0800, enc_i(6'b000001, 5'd3, 5'b00010, 16'h0010), 32'hFFFF_FFFF, 0);
    expect_out("R2 unused rt code", 32'h0000_0804, 0, 0, 0, 0);
  endtask

  task automatic t_compare;
    drive(32'h0000_1000, enc_i(6'b000100, 5'd3, 5'd4, 16'd4), 32'h77, 32'h77);
    expect_out("R3 eq taken", 32'h0000_1014, 1, 0, 0, 0);
    drive(32'h0000_1000, enc_i(6'b000100, 5'd3, 5'd4, 16'd4), 32'h77, 32'h78);
    expect_out("R3 eq not taken", 32'h0000_1004, 0, 0, 0, 0);
    drive(32'h0000_1000, enc_i(6'b000101, 5'd3, 5'd4, 16'hFFFE), 32'h1, 32'h2);
    expect_out("R3 R9 ne backward", 32'h0000_0FFC, 1, 0, 0, 0);
  endtask

  task automatic t_zero_tests;
    drive(32'h0000_2000, enc_i(6'b000110, 5'd1, 5'd0, 16'd2), 32'h0, 32'h1234);
    expect_out("R4 lez zero", 32'h0000_200C, 1, 0, 0, 0);
    drive(32'h0000_2000, enc_i(6'b000110, 5'd1, 5'd0, 16'd2), 32'hFFFF_FFFB, 32'h0);
    expect_out("R4 lez negative", 32'h0000_200C, 1, 0, 0, 0);
    drive(32'h0000_2000, enc_i(6'b000111, 5'd1, 5'd0, 16'd2), 32'h1, 32'hFFFF_FFFF);
    expect_out("R4 gtz positive rt ignored", 32'h0000_200C, 1, 0, 0, 0);
    drive(32'h0000_2000, enc_i(6'b000111, 5'd1, 5'd0, 16'd2), 32'h0, 32'h1);
    expect_out("R4 gtz zero", 32'h0000_2004, 0, 0, 0, 0);
  endtask

  task automatic t_sign_group;
    drive(32'h0000_3000, enc_i(6'b000001, 5'd2, 5'b10000, 16'd8), 32'hFFFF_FFFF, 0);
    expect_out("R5 R6 ltz link taken", 32'h0000_3024, 1, 1, 5'd31, 32'h0000_3004);
    drive(32'h0000_3000, enc_i(6'b000001, 5'd2, 5'b10000, 16'd8), 32'h0, 0);
    expect_out("R6 ltz link not taken", 32'h0000_3004, 0, 0, 0, 0);
    drive(32'h0000_3000, enc_i(6'b000001, 5'd2, 5'b00001, 16'd8), 32'h0, 0);
    expect_out("R5 gez zero", 32'h0000_3024, 1, 0, 0, 0);
    drive(32'h0000_3000, enc_i(6'b000001, 5'd2, 5'b00000, 16'd8), 32'h5, 0);
    expect_out("R5 ltz positive", 32'h0000_3004, 0, 0, 0, 0);
    drive(32'h0000_3000, enc_i(6'b000001, 5'd2, 5'b10001, 16'hFFFF), 32'h7, 0);
    expect_out("R5 R6 gez link", 32'h0000_3000, 1, 1, 5'd31, 32'h0000_3004);
  endtask

  task automatic t_direct;
    drive(32'h0040_0000, enc_j(6'b000010, 26'h20), 0, 0);
    expect_out("R7 plain", 32'h0000_0080, 1, 0, 0, 0);
    drive(32'hA000_0010, enc_j(6'b000011, 26'h3FF_FFFF), 0, 0);
    expect_out("R7 link", 32'hAFFF_FFFC, 1, 1, 5'd31, 32'hA000_0014);
    drive(32'h1FFF_FFFC, enc_j(6'b000010, 26'h10), 0, 0);
    expect_out("R10 region from next", 32'h2000_0040, 1, 0, 0, 0);
  endtask

  task automatic t_regjump;
    drive(32'h0000_5000, enc_r(5'd9, 5'd0, 6'b001000), 32'h1234_5678, 0);
    expect_out("R8 reg plain", 32'h1234_5678, 1, 0, 0, 0);
    drive(32'h0000_5000, enc_r(5'd9, 5'd5, 6'b001001), 32'h0000_9000, 0);
    expect_out("R8 reg link rd5", 32'h0000_9000, 1, 1, 5'd5, 32'h0000_5004);
    drive(32'h0000_5000, enc_r(5'd9, 5'd31, 6'b001001), 32'h0000_A000, 0);
    expect_out("R8 reg link rd31", 32'h0000_A000, 1, 1, 5'd31, 32'h0000_5004);
  endtask

  task automatic t_wrap;
    drive(32'hFFFF_FFF8, enc_i(6'b000100, 5'd1, 5'd2, 16'd1), 32'h3, 32'h3);
    expect_out("R9 wrap forward", 32'h0000_0000, 1, 0, 0, 0);
    drive(32'hFFFF_FFFC, 32'h0000_0000, 0, 0);
    expect_out("R9 R2 seq wrap", 32'h0000_0000, 0, 0, 0, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_plain();
    t_compare();
    t_zero_tests();
    t_sign_group();
    t_direct();
    t_regjump();
    t_wrap();
    finish_run();
  end
endmodule